// File: doc/BRIEF.md
# Register-Driven Signed Integer Divider

This block is a small arithmetic coprocessor that a processor drives through a word-wide register port. Software writes a numerator and a denominator as two 32-bit halves each, picks an operand width in a control register, and then polls a busy bit. When busy clears, the quotient and remainder can be read back, each as two 32-bit halves. Any write to the control register or to an operand half starts a new division. A write that arrives while a division is running abandons that division and starts over with the register contents as they now stand.

The datapath is a one-bit-per-cycle restoring divider that works on magnitudes, followed by a sign fix-up stage. Three operand modes are supported: 32 by 32, 64 by 32 and 64 by 64. A zero divisor and the single overflowing case (most negative 64-bit value divided by minus one) both give fixed results and set a shared error bit.

Top module: `sdiv_mmio`

## Requirements
- R1: After reset, the control word reads 0 (idle, no error, mode 0) and every quotient and remainder half reads 0.
- R2: Two things set the busy bit (control bit 15) on the next cycle: a write to the control word (word address 0), and a write to any operand half (word addresses 4 to 7). Busy then stays set for exactly 66 cycles after the last such write, and a write made while busy restarts the count and the computation.
- R3: In mode 0 (control bits [1:0] = 0), both operands are the sign extension of their low 32 bits, and the high halves are ignored.
- R4: In modes 1 and 3, the numerator is used at its full 64 bits and the denominator is the sign extension of its low 32 bits.
- R5: In mode 2, both operands are used at their full 64 bits.
- R6: For a nonzero divisor, outside the overflow case, the quotient truncates toward zero, the remainder takes the sign of the numerator, and the error bit (control bit 14) is cleared.
- R7: When the effective divisor is zero, the remainder becomes the effective numerator, the quotient becomes 1 if the numerator is negative and 0 otherwise, and the error bit is set.
- R8: When the effective numerator is the most negative 64-bit value and the effective divisor is -1, the quotient becomes the numerator, the remainder keeps its previous value, and the error bit is set.
- R9: While busy is set, the quotient, the remainder and the error bit keep their previous values. They change only at the cycle in which busy clears.
- R10: The word addresses are as follows. Numerator: low half 4, high half 5. Denominator: low half 6, high half 7. Quotient: low half 8, high half 9. Remainder: low half 10, high half 11. The result words are read-only, and a write to them neither changes them nor starts a division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |

## Verification
The bench goes after the operand-width corners. It loads high halves full of noise in mode 0, and loads a denominator whose low half is zero or all ones in the 64-by-32 modes. A design that truncated or sign-extended the wrong operand would then return a quotient far from the reference. It drives both error paths. A zero-divisor design that got the rules wrong would return a wrong quotient polarity. An overflow design that got them wrong would overwrite the remainder, or would let the error bit stick after the next good division. It also restarts a division mid-run by changing the mode. A design that kept the stale computation would finish early, with results from the old mode.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned BUS_W    = DATA_W / 2;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned BUSY_BIT = 15;
  localparam int unsigned ERR_BIT  = 14;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_NUM_LO = 4'd4;
  localparam logic [ADDR_W-1:0] A_NUM_HI = 4'd5;
  localparam logic [ADDR_W-1:0] A_DEN_LO = 4'd6;
  localparam logic [ADDR_W-1:0] A_DEN_HI = 4'd7;
  localparam logic [ADDR_W-1:0] A_QUO_LO = 4'd8;
  localparam logic [ADDR_W-1:0] A_QUO_HI = 4'd9;
  localparam logic [ADDR_W-1:0] A_REM_LO = 4'd10;
  localparam logic [ADDR_W-1:0] A_REM_HI = 4'd11;

  typedef enum logic [MODE_W-1:0] {
    MODE_S32 = 2'd0,
    MODE_N64 = 2'd1,
    MODE_F64 = 2'd2,
    MODE_N64_ALT = 2'd3
  } sdiv_mode_e;

  typedef struct packed {
    logic [DATA_W-1:0] num_eff;
    logic [DATA_W-1:0] num_mag;
    logic [DATA_W-1:0] den_mag;
    logic              q_neg;
    logic              r_neg;
    logic              den_zero;
    logic              ovf;
  } sdiv_op_t;
endpackage

// File: rtl/sdiv_operand_prep.sv
module sdiv_operand_prep
  import sdiv_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DATA_W-1:0] num_i,
  input  logic [DATA_W-1:0] den_i,
  output sdiv_op_t          op_o
);
  logic [DATA_W-1:0] n_eff, d_eff, n_sx, d_sx;
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  assign n_sx = {{BUS_W{num_i[BUS_W-1]}}, num_i[BUS_W-1:0]};
  assign d_sx = {{BUS_W{den_i[BUS_W-1]}}, den_i[BUS_W-1:0]};

  always_comb begin
    case (sdiv_mode_e'(mode_i))
      MODE_S32: begin n_eff = n_sx;  d_eff = d_sx;  end
      MODE_F64: begin n_eff = num_i; d_eff = den_i; end
      default:  begin n_eff = num_i; d_eff = d_sx;  end
    endcase
  end

  always_comb begin
    op_o.num_eff  = n_eff;
    op_o.num_mag  = n_eff[DATA_W-1] ? (~n_eff + 1'b1) : n_eff;
    op_o.den_mag  = d_eff[DATA_W-1] ? (~d_eff + 1'b1) : d_eff;
    op_o.q_neg    = n_eff[DATA_W-1] ^ d_eff[DATA_W-1];
    op_o.r_neg    = n_eff[DATA_W-1];
    op_o.den_zero = (d_eff == '0);
    op_o.ovf      = (n_eff == MOST_NEG) && (d_eff == '1);
  end
endmodule

// File: rtl/sdiv_iter_core.sv
module sdiv_iter_core
  import sdiv_pkg::*;
#(
  parameter int unsigned W = sdiv_pkg::DATA_W
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  sdiv_op_t op_i,
  output sdiv_op_t op_o,
  output logic     done_o,
  output logic [W-1:0] quo_mag_o,
  output logic [W-1:0] rem_mag_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     acc_q, qsh_q;
  sdiv_op_t         op_q;

  logic [W:0]   shifted, trial;
  logic         ge;
  logic [W-1:0] acc_n, qsh_n;

  // restoring step: shift in next numerator bit, subtract if it fits
  always_comb begin
    shifted = {acc_q, qsh_q[W-1]};
    trial   = shifted - {1'b0, op_q.den_mag};
    ge      = ~trial[W];
    acc_n   = ge ? trial[W-1:0] : shifted[W-1:0];
    qsh_n   = {qsh_q[W-2:0], ge};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      acc_q <= '0;
      qsh_q <= '0;
      op_q  <= '0;
    end else if (load_i) begin
      run_q <= 1'b1;
      cnt_q <= CNT_W'(W);
      acc_q <= '0;
      qsh_q <= op_i.num_mag;
      op_q  <= op_i;
    end else if (run_q) begin
      if (cnt_q != '0) begin
        acc_q <= acc_n;
        qsh_q <= qsh_n;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        run_q <= 1'b0;
      end
    end
  end

  assign done_o    = run_q && (cnt_q == '0);
  assign op_o      = op_q;
  assign quo_mag_o = qsh_q;
  assign rem_mag_o = acc_q;
endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup
  import sdiv_pkg::*;
(
  input  sdiv_op_t          op_i,
  input  logic [DATA_W-1:0] quo_mag_i,
  input  logic [DATA_W-1:0] rem_mag_i,
  output logic [DATA_W-1:0] quo_o,
  output logic [DATA_W-1:0] rem_o,
  output logic              rem_we_o,
  output logic              err_o
);
  always_comb begin
    quo_o    = op_i.q_neg ? (~quo_mag_i + 1'b1) : quo_mag_i;
    rem_o    = op_i.r_neg ? (~rem_mag_i + 1'b1) : rem_mag_i;
    rem_we_o = 1'b1;
    err_o    = 1'b0;
    if (op_i.den_zero) begin
      quo_o = DATA_W'(op_i.r_neg);
      rem_o = op_i.num_eff;
      err_o = 1'b1;
    end else if (op_i.ovf) begin
      quo_o    = op_i.num_eff;
      rem_we_o = 1'b0;
      err_o    = 1'b1;
    end
  end
endmodule

// File: rtl/sdiv_mmio.sv
module sdiv_mmio
  import sdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o
);
  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] num_q, den_q, quo_q, rem_q;
  logic              busy_q, err_q, start_q;

  logic              wr_start, fire;
  sdiv_op_t          prep_op, held_op;
  logic              core_done;
  logic [DATA_W-1:0] quo_mag, rem_mag, fix_quo, fix_rem;
  logic              fix_rem_we, fix_err;

  always_comb begin
    wr_start = 1'b0;
    if (wr_en_i) begin
      case (addr_i)
        A_CTRL, A_NUM_LO, A_NUM_HI, A_DEN_LO, A_DEN_HI: wr_start = 1'b1;
        default: wr_start = 1'b0;
      endcase
    end
  end

  // a pending or fresh restart suppresses write-back of the stale run
  assign fire = core_done && !start_q && !wr_start;

  sdiv_operand_prep u_prep (
    .mode_i (mode_q),
    .num_i  (num_q),
    .den_i  (den_q),
    .op_o   (prep_op)
  );

  sdiv_iter_core #(.W(DATA_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_q),
    .op_i      (prep_op),
    .op_o      (held_op),
    .done_o    (core_done),
    .quo_mag_o (quo_mag),
    .rem_mag_o (rem_mag)
  );

  sdiv_fixup u_fix (
    .op_i      (held_op),
    .quo_mag_i (quo_mag),
    .rem_mag_i (rem_mag),
    .quo_o     (fix_quo),
    .rem_o     (fix_rem),
    .rem_we_o  (fix_rem_we),
    .err_o     (fix_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      num_q   <= '0;
      den_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= wr_start;
      if (wr_en_i) begin
        case (addr_i)
          A_CTRL:   mode_q               <= wdata_i[MODE_W-1:0];
          A_NUM_LO: num_q[BUS_W-1:0]     <= wdata_i;
          A_NUM_HI: num_q[DATA_W-1:BUS_W] <= wdata_i;
          A_DEN_LO: den_q[BUS_W-1:0]     <= wdata_i;
          A_DEN_HI: den_q[DATA_W-1:BUS_W] <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      quo_q  <= '0;
      rem_q  <= '0;
    end else begin
      if (wr_start)  busy_q <= 1'b1;
      else if (fire) busy_q <= 1'b0;
      if (fire) begin
        quo_q <= fix_quo;
        err_q <= fix_err;
        if (fix_rem_we) rem_q <= fix_rem;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[BUSY_BIT]     = busy_q;
        rdata_o[ERR_BIT]      = err_q;
        rdata_o[MODE_W-1:0]   = mode_q;
      end
      A_NUM_LO: rdata_o = num_q[BUS_W-1:0];
      A_NUM_HI: rdata_o = num_q[DATA_W-1:BUS_W];
      A_DEN_LO: rdata_o = den_q[BUS_W-1:0];
      A_DEN_HI: rdata_o = den_q[DATA_W-1:BUS_W];
      A_QUO_LO: rdata_o = quo_q[BUS_W-1:0];
      A_QUO_HI: rdata_o = quo_q[DATA_W-1:BUS_W];
      A_REM_LO: rdata_o = rem_q[BUS_W-1:0];
      A_REM_HI: rdata_o = rem_q[DATA_W-1:BUS_W];
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sdiv_mmio_chk.sv
module sdiv_mmio_chk
  import sdiv_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              busy_i,
  input logic              err_i,
  input logic [DATA_W-1:0] quo_i,
  input logic [DATA_W-1:0] rem_i
);
  localparam int unsigned LAT   = DATA_W + 2;
  localparam int unsigned LAT_W = $clog2(LAT + 2) + 1;

  logic             start_w;
  logic [LAT_W-1:0] lat_cnt;

  assign start_w = wr_en_i && ((addr_i == A_CTRL) ||
                   ((addr_i >= A_NUM_LO) && (addr_i <= A_DEN_HI)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       lat_cnt <= '0;
    else if (start_w)                  lat_cnt <= '0;
    else if (busy_i && lat_cnt != '1)  lat_cnt <= lat_cnt + 1'b1;
  end

  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> busy_i); // R2
  AST_BUSY_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (lat_cnt == LAT_W'(LAT))); // R2
  AST_QUO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(quo_i) |-> $fell(busy_i)); // R9
  AST_REM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rem_i) |-> $fell(busy_i)); // R9
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_i) |-> $fell(busy_i)); // R9
endmodule

bind sdiv_mmio sdiv_mmio_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .busy_i  (busy_q),
  .err_i   (err_q),
  .quo_i   (quo_q),
  .rem_i   (rem_q)
);

// File: tb/sdiv_mmio_test.sv
module sdiv_mmio_test;
  localparam int LAT = 66;
  localparam logic [63:0] MOST_NEG = 64'h8000_0000_0000_0000;

  typedef struct {
    logic [63:0] q;
    logic [63:0] r;
    logic        e;
    logic [63:0] prev_q;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int tests = 0;
  int fails = 0;
  bit mon_active = 0;
  bit finished = 0;
  exp_t exp_q[$];
  logic [63:0] last_q = '0;
  logic [63:0] last_r = '0;

  always #5 clk = ~clk;

  sdiv_mmio uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called right after a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic rd64(input logic [3:0] a_lo, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a_lo, lo);
    rd(a_lo + 4'd1, hi);
    d = {hi, lo};
  endtask

  function automatic void model(input logic [1:0] mode, input logic [63:0] num,
                                input logic [63:0] den, output exp_t it);
    longint n, d;
    n = (mode == 2'd0) ? {{32{num[31]}}, num[31:0]} : num;
    d = (mode == 2'd2) ? den : {{32{den[31]}}, den[31:0]};
    it.prev_q = last_q;
    if (d == 0) begin
      it.q = (n < 0) ? 64'd1 : 64'd0; it.r = n; it.e = 1'b1;
    end else if (n == MOST_NEG && d == -1) begin
      it.q = n; it.r = last_r; it.e = 1'b1;
    end else begin
      it.q = n / d; it.r = n % d; it.e = 1'b0;
    end
    last_q = it.q;
    last_r = it.r;
  endfunction

  task automatic load_ops(input logic [63:0] num, input logic [63:0] den);
    wr(4'd4, num[31:0]);  wr(4'd5, num[63:32]);
    wr(4'd6, den[31:0]);  wr(4'd7, den[63:32]);
  endtask

  task automatic run_op(input string tag, input logic [1:0] mode,
                        input logic [63:0] num, input logic [63:0] den);
    exp_t it;
    model(mode, num, den, it);
    it.tag = tag;
    load_ops(num, den);
    wr(4'd0, {30'd0, mode});
    exp_q.push_back(it);
    wait (exp_q.size() == 0 && !mon_active);
    @(negedge clk);
  endtask

  // start in one mode, then switch mode mid-run
  task automatic run_restart(input string tag, input logic [1:0] mode_a,
                             input logic [1:0] mode_b,
                             input logic [63:0] num, input logic [63:0] den);
    exp_t it;
    load_ops(num, den);
    wr(4'd0, {30'd0, mode_a});
    repeat (20) @(negedge clk);
    model(mode_b, num, den, it);
    it.tag = tag;
    wr(4'd0, {30'd0, mode_b});
    exp_q.push_back(it);
    wait (exp_q.size() == 0 && !mon_active);
    @(negedge clk);
  endtask

  // monitor: measures busy, checks hold, then compares results
  initial begin
    forever begin
      exp_t it;
      int cnt;
      bit first;
      logic [31:0] c;
      logic [63:0] v;
      wait (exp_q.size() != 0);
      mon_active = 1;
      it = exp_q.pop_front();
      cnt = 0;
      first = 1;
      while (1) begin
        rd(4'd0, c);
        if (!c[15]) break;
        if (first) begin
          rd64(4'd8, v);
          check({"R9 ", it.tag}, "quotient held while busy", v, it.prev_q);
          first = 0;
        end
        cnt++;
        if (cnt > 1000) break;
        @(negedge clk);
      end
      check({"R2 ", it.tag}, "busy cycles", 64'(cnt), 64'(LAT));
      rd64(4'd8, v);
      check(it.tag, "quotient", v, it.q);
      rd64(4'd10, v);
      check(it.tag, "remainder", v, it.r);
      rd(4'd0, c);
      check(it.tag, "error bit", 64'(c[14]), 64'(it.e));
      mon_active = 0;
    end
  end

  initial begin
    #(10 * 200000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] c;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'd0, c);
    check("R1", "control after reset", 64'(c), 64'd0);
    rd64(4'd8, v);
    check("R1", "quotient after reset", v, 64'd0);
    rd64(4'd10, v);
    check("R1", "remainder after reset", v, 64'd0);
    @(negedge clk);

    run_op("R3 neg/pos noisy high", 2'd0, 64'h1234_5678_FFFF_FF9C, 64'hDEAD_0000_0000_0007);
    run_op("R3 pos/neg", 2'd0, 64'hFFFF_0000_0000_03E8, 64'h0000_0001_FFFF_FFFD);
    run_op("R3 min32/-1", 2'd0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);
    run_op("R4 mode1", 2'd1, 64'hFFFF_FF17_2B5A_F000, 64'h5555_0000_FFFF_FFF9);
    run_op("R4 mode3", 2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0001_0000);
    run_op("R5 mode2 big", 2'd2, 64'h8123_4567_89AB_CDEF, 64'h0000_0012_3456_789A);
    run_op("R6 -7/2", 2'd2, -64'sd7, 64'd2);
    run_op("R7 zero div neg", 2'd2, -64'sd12345, 64'd0);
    run_op("R6 clears err", 2'd2, 64'd100, -64'sd9);
    run_op("R7 zero div low half", 2'd1, 64'd77, 64'hABCD_0000_0000_0000);
    run_op("R8 overflow mode2", 2'd2, MOST_NEG, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R8 overflow mode1", 2'd1, MOST_NEG, 64'h0000_0000_FFFF_FFFF);
    run_op("R6 after ovf", 2'd2, MOST_NEG, 64'd3);
    run_restart("R2 restart mode0->2", 2'd0, 2'd2, 64'h0000_0010_0000_0064, 64'h0000_0001_0000_0005);

    // R10: writes to result words ignored
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd11, 32'h1234_5678);
    rd(4'd0, c);
    check("R10", "busy after result write", 64'(c[15]), 64'd0);
    rd64(4'd8, v);
    check("R10", "quotient after write", v, last_q);
    rd64(4'd10, v);
    check("R10", "remainder after write", v, last_r);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule